// File: doc/BRIEF.md
# Three-Wire Serial Programming Port

This block accepts configuration words for a frequency synthesizer over three serial lines: a serial clock, a data line and a latch strobe. It runs in a system-clock domain and oversamples all three lines. Each rising edge of the serial clock shifts one data bit into a 24-bit word. A rising edge of the latch strobe commits the word to one of three destination registers. The two lowest bits of the word pick the destination.

The destinations are a reference-divider value (14 bits), a pair of feedback counter values (6-bit swallow count and 13-bit main count), and a 22-bit function word. A word with the wrong bit count is discarded and raises a sticky framing flag. A reference-divider word whose divider field is zero is handled the same way. While words arrive, a monitor measures setup, hold, clock-high, clock-low, clock-to-strobe and strobe-width timing in system-clock cycles. Any violation raises a sticky timing flag.

Top module: `tw_prog_port`

## Requirements
- R1: After reset the reference divider reads 1, the swallow count, main count and function word read 0, and both error flags are low.
- R2: Bits are shifted in MSB first, one per synchronized rising edge of the serial clock, and the word is committed on the synchronized rising edge of the latch strobe. Word bits [1:0] select the destination.
- R3: Select 00 loads word bits [15:2] into the reference divider. A divider field of 0 is rejected: the divider keeps its value and the framing flag is set.
- R4: Select 01 loads word bits [7:2] into the swallow count and word bits [20:8] into the main count.
- R5: Select 10 loads word bits [23:2] into the function word.
- R6: Select 11 changes no output and raises no flag.
- R7: A strobe after a bit count other than exactly 24 since the previous strobe (or reset) changes no destination and sets the framing flag, which stays set.
- R8: A serial-clock high time shorter than the clock-high limit, given in nanoseconds and rounded up to system cycles, sets the timing flag. The flag stays set through later valid words.
- R9: A latch-strobe rising edge arriving within the clock-to-strobe limit of a serial-clock rising edge (the same synchronized cycle with the default limits) sets the timing flag.
- R10: Reset clears both flags and returns all destinations to their R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock line (asynchronous) |
| ser_data_i | input | 1 | Serial data line (asynchronous) |
| ser_le_i | input | 1 | Latch strobe line (asynchronous) |
| ref_div_o | output | 14 | Reference divider value |
| swallow_o | output | 6 | Swallow count |
| main_cnt_o | output | 13 | Main count |
| func_o | output | 22 | Function word |
| timing_err_o | output | 1 | Sticky serial timing violation flag |
| frame_err_o | output | 1 | Sticky bad-count or zero-divider flag |

## Verification
The main path is driven with words for every destination. The field values are all-ones, minimum values, alternating bits and mid-range numbers. Alternating and asymmetric patterns catch a reversed shift order or a shifted field. Writes to one destination followed by checks on the others catch select decoding that spills into the wrong register. Short and long frames, the reserved select and a zero divider each show whether a bad word is discarded or wrongly committed. A one-cycle clock pulse and a strobe that coincides with a clock edge show whether the timing monitor counts durations or only sees edges.

// File: rtl/tw_prog_pkg.sv
package tw_prog_pkg;
  localparam int WORD_W = 24;

  typedef enum logic [1:0] {
    SEL_REF  = 2'b00,
    SEL_CNT  = 2'b01,
    SEL_FUNC = 2'b10,
    SEL_RSVD = 2'b11
  } latch_sel_e;

  localparam int LN_DATA = 0;
  localparam int LN_SCLK = 1;
  localparam int LN_LE   = 2;

  function automatic int ns_to_cyc(input int ns, input int per_ps);
    return (ns * 1000 + per_ps - 1) / per_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int N_LINES = 3,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] raw_i,
  output logic [N_LINES-1:0] lvl_o,
  output logic [N_LINES-1:0] rise_o,
  output logic [N_LINES-1:0] fall_o,
  output logic [N_LINES-1:0] chg_o
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic [STAGES:0] pipe_q;
    always_ff @(posedge clk) begin
      if (rst) pipe_q <= '0;
      else     pipe_q <= {pipe_q[STAGES-1:0], raw_i[i]};
    end
    assign lvl_o[i]  = pipe_q[STAGES-1];
    assign rise_o[i] = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o[i] = ~pipe_q[STAGES-1] & pipe_q[STAGES];
    assign chg_o[i]  = pipe_q[STAGES-1] ^ pipe_q[STAGES];
  end
endmodule

// File: rtl/tw_timing_mon.sv
module tw_timing_mon
  import tw_prog_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int HOLD_CYC  = 1,
  parameter int HIGH_CYC  = 2,
  parameter int LOW_CYC   = 2,
  parameter int C2LE_CYC  = 1,
  parameter int LEPW_CYC  = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] rise_i,
  input  logic [2:0] fall_i,
  input  logic [2:0] chg_i,
  output logic       timing_err_o
);
  localparam int LIM_MAX = imax(imax(imax(SETUP_CYC, HOLD_CYC), imax(HIGH_CYC, LOW_CYC)),
                                imax(C2LE_CYC, LEPW_CYC));
  localparam int AGE_W = $clog2(LIM_MAX + 2) + 1;
  localparam logic [AGE_W-1:0] AGE_MAX  = '1;
  localparam logic [AGE_W-1:0] SETUP_L  = AGE_W'(SETUP_CYC);
  localparam logic [AGE_W-1:0] HOLD_L   = AGE_W'(HOLD_CYC);
  localparam logic [AGE_W-1:0] HIGH_L   = AGE_W'(HIGH_CYC);
  localparam logic [AGE_W-1:0] LOW_L    = AGE_W'(LOW_CYC);
  localparam logic [AGE_W-1:0] C2LE_L   = AGE_W'(C2LE_CYC);
  localparam logic [AGE_W-1:0] LEPW_L   = AGE_W'(LEPW_CYC);

  // cycles each synchronized line has held its level, saturating
  logic [AGE_W-1:0] age_q [3];
  for (genvar i = 0; i < 3; i++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst)                   age_q[i] <= AGE_MAX;
      else if (chg_i[i])         age_q[i] <= AGE_W'(1);
      else if (age_q[i] != AGE_MAX) age_q[i] <= age_q[i] + 1'b1;
    end
  end

  logic [AGE_W-1:0] since_rise_q;
  always_ff @(posedge clk) begin
    if (rst)                          since_rise_q <= AGE_MAX;
    else if (rise_i[LN_SCLK])         since_rise_q <= AGE_W'(1);
    else if (since_rise_q != AGE_MAX) since_rise_q <= since_rise_q + 1'b1;
  end

  logic [AGE_W-1:0] data_stable, rise_gap;
  logic v_setup, v_hold, v_high, v_low, v_c2le, v_lepw;
  always_comb begin
    data_stable = chg_i[LN_DATA] ? '0 : age_q[LN_DATA];
    rise_gap    = rise_i[LN_SCLK] ? '0 : since_rise_q;
    v_setup = rise_i[LN_SCLK] && (data_stable < SETUP_L);
    v_hold  = chg_i[LN_DATA] && !rise_i[LN_SCLK] && (since_rise_q < HOLD_L);
    v_high  = fall_i[LN_SCLK] && (age_q[LN_SCLK] < HIGH_L);
    v_low   = rise_i[LN_SCLK] && (age_q[LN_SCLK] < LOW_L);
    v_c2le  = rise_i[LN_LE] && (rise_gap < C2LE_L);
    v_lepw  = fall_i[LN_LE] && (age_q[LN_LE] < LEPW_L);
  end

  logic err_q;
  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= err_q | v_setup | v_hold | v_high | v_low | v_c2le | v_lepw;
  end
  assign timing_err_o = err_q;

  // R8: once raised the flag holds until reset
  a_r8_timing_sticky: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
endmodule

// File: rtl/tw_shift_dec.sv
module tw_shift_dec
  import tw_prog_pkg::*;
#(
  parameter int REF_W  = 14,
  parameter int SWL_W  = 6,
  parameter int MAIN_W = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_stb_i,
  input  logic                bit_i,
  input  logic                commit_i,
  output logic [REF_W-1:0]    ref_div_o,
  output logic [SWL_W-1:0]    swallow_o,
  output logic [MAIN_W-1:0]   main_cnt_o,
  output logic [WORD_W-3:0]   func_o,
  output logic                frame_err_o
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (bit_stb_i) shreg_q <= {shreg_q[WORD_W-2:0], bit_i};
      if (commit_i)                          cnt_q <= '0;
      else if (bit_stb_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  latch_sel_e       sel;
  logic [REF_W-1:0] ref_fld;
  logic             len_ok, ref_zero, take;
  always_comb begin
    sel      = latch_sel_e'(shreg_q[1:0]);
    ref_fld  = shreg_q[REF_W+1:2];
    len_ok   = (cnt_q == CNT_FULL);
    ref_zero = (sel == SEL_REF) && (ref_fld == '0);
    take     = commit_i && len_ok && !ref_zero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_div_o   <= REF_W'(1);
      swallow_o   <= '0;
      main_cnt_o  <= '0;
      func_o      <= '0;
      frame_err_o <= 1'b0;
    end else begin
      if (commit_i && (!len_ok || ref_zero)) frame_err_o <= 1'b1;
      if (take) begin
        case (sel)
          SEL_REF:  ref_div_o <= ref_fld;
          SEL_CNT: begin
            swallow_o  <= shreg_q[SWL_W+1:2];
            main_cnt_o <= shreg_q[MAIN_W+SWL_W+1:SWL_W+2];
          end
          SEL_FUNC: func_o <= shreg_q[WORD_W-1:2];
          default:  ;
        endcase
      end
    end
  end

  // R7: a wrong-length frame leaves every destination untouched
  a_r7_short_long_discard: assert property (@(posedge clk) disable iff (rst)
    (commit_i && !len_ok) |=> ($stable(ref_div_o) && $stable(swallow_o) &&
                               $stable(main_cnt_o) && $stable(func_o) && frame_err_o));
  // R6: reserved select commits nothing
  a_r6_reserved_ignored: assert property (@(posedge clk) disable iff (rst)
    (commit_i && sel == SEL_RSVD) |=> ($stable(ref_div_o) && $stable(swallow_o) &&
                                       $stable(main_cnt_o) && $stable(func_o)));
  // R3: zero divider rejected, nonzero divider taken
  a_r3_zero_divider: assert property (@(posedge clk) disable iff (rst)
    (commit_i && len_ok && ref_zero) |=> ($stable(ref_div_o) && frame_err_o));
  a_r3_divider_load: assert property (@(posedge clk) disable iff (rst)
    (take && sel == SEL_REF) |=> (ref_div_o == $past(ref_fld)));
  // R7: framing flag is sticky
  a_r7_frame_sticky: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |=> frame_err_o);
endmodule

// File: rtl/tw_prog_port.sv
module tw_prog_port
  import tw_prog_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 20000,
  parameter int SYNC_STAGES   = 2,
  parameter int SETUP_NS      = 10,
  parameter int HOLD_NS       = 10,
  parameter int HIGH_NS       = 25,
  parameter int LOW_NS        = 25,
  parameter int C2LE_NS       = 10,
  parameter int LEPW_NS       = 20,
  parameter int REF_W         = 14,
  parameter int SWL_W         = 6,
  parameter int MAIN_W        = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_data_i,
  input  logic              ser_le_i,
  output logic [REF_W-1:0]  ref_div_o,
  output logic [SWL_W-1:0]  swallow_o,
  output logic [MAIN_W-1:0] main_cnt_o,
  output logic [WORD_W-3:0] func_o,
  output logic              timing_err_o,
  output logic              frame_err_o
);
  logic [2:0] raw, lvl, rise, fall, chg;
  always_comb begin
    raw          = '0;
    raw[LN_DATA] = ser_data_i;
    raw[LN_SCLK] = ser_clk_i;
    raw[LN_LE]   = ser_le_i;
  end

  tw_sync #(.N_LINES(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .raw_i(raw),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall), .chg_o(chg)
  );

  tw_timing_mon #(
    .SETUP_CYC(ns_to_cyc(SETUP_NS, CLK_PERIOD_PS)),
    .HOLD_CYC (ns_to_cyc(HOLD_NS,  CLK_PERIOD_PS)),
    .HIGH_CYC (ns_to_cyc(HIGH_NS,  CLK_PERIOD_PS)),
    .LOW_CYC  (ns_to_cyc(LOW_NS,   CLK_PERIOD_PS)),
    .C2LE_CYC (ns_to_cyc(C2LE_NS,  CLK_PERIOD_PS)),
    .LEPW_CYC (ns_to_cyc(LEPW_NS,  CLK_PERIOD_PS))
  ) mon_i (
    .clk(clk), .rst(rst), .rise_i(rise), .fall_i(fall), .chg_i(chg),
    .timing_err_o(timing_err_o)
  );

  tw_shift_dec #(.REF_W(REF_W), .SWL_W(SWL_W), .MAIN_W(MAIN_W)) dec_i (
    .clk(clk), .rst(rst),
    .bit_stb_i(rise[LN_SCLK]), .bit_i(lvl[LN_DATA]), .commit_i(rise[LN_LE]),
    .ref_div_o(ref_div_o), .swallow_o(swallow_o), .main_cnt_o(main_cnt_o),
    .func_o(func_o), .frame_err_o(frame_err_o)
  );
endmodule

// File: tb/tw_prog_port_tb.sv
module tw_prog_port_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdata = 1'b0, sle = 1'b0;
  logic [13:0] ref_div;
  logic [5:0]  swallow;
  logic [12:0] main_cnt;
  logic [21:0] func;
  logic        terr, ferr;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  tw_prog_port dut_i (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_data_i(sdata), .ser_le_i(sle),
    .ref_div_o(ref_div), .swallow_o(swallow), .main_cnt_o(main_cnt), .func_o(func),
    .timing_err_o(terr), .frame_err_o(ferr)
  );

  // expected state, built from the requirements
  logic [13:0] e_ref;
  logic [5:0]  e_swl;
  logic [12:0] e_main;
  logic [21:0] e_func;

  localparam int NV = 7;
  localparam logic [23:0] VEC [NV] = '{
    {8'h00, 14'd1,      2'b00},
    {8'hA5, 14'h3FFF,   2'b00},
    {3'b101, 13'h1FFF, 6'h3F, 2'b01},
    {3'b010, 13'd891,  6'd5,  2'b01},
    {22'h2AAAAA, 2'b10},
    {22'h155555, 2'b10},
    {8'h3C, 14'd1000,   2'b00}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; sclk = 0; sdata = 0; sle = 0;
    tick(4);
    rst = 1'b0;
    tick(2);
    e_ref = 14'd1; e_swl = '0; e_main = '0; e_func = '0;
  endtask

  task automatic send_bits(input logic [31:0] w, input int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      sdata = w[i]; tick(3);
      sclk = 1'b1;  tick(3);
      sclk = 1'b0;  tick(3);
    end
    sle = 1'b1; tick(3);
    sle = 1'b0; tick(6);
  endtask

  task automatic model_word(input logic [23:0] w);
    case (w[1:0])
      2'b00: if (w[15:2] != 0) e_ref = w[15:2];
      2'b01: begin e_swl = w[7:2]; e_main = w[20:8]; end
      2'b10: e_func = w[23:2];
      default: ;
    endcase
  endtask

  task automatic chk_fields(input string req);
    n_chk++;
    if ({ref_div, swallow, main_cnt, func} !== {e_ref, e_swl, e_main, e_func}) begin
      n_bad++;
      $display("FAIL %s fields act ref=%0d swl=%0d main=%0d func=%h exp ref=%0d swl=%0d main=%0d func=%h",
               req, ref_div, swallow, main_cnt, func, e_ref, e_swl, e_main, e_func);
    end
  endtask

  task automatic chk_flags(input string req, input logic et, input logic ef);
    n_chk++;
    if ({terr, ferr} !== {et, ef}) begin
      n_bad++;
      $display("FAIL %s flags act terr=%b ferr=%b exp terr=%b ferr=%b", req, terr, ferr, et, ef);
    end
  endtask

  bit done = 0;

  initial begin
    do_reset();
    chk_fields("R1 reset values");
    chk_flags("R1 reset flags", 0, 0);

    // R2 R3 R4 R5: table of words, each committed and checked
    for (int i = 0; i < NV; i++) begin
      send_bits({8'h0, VEC[i]}, 24);
      model_word(VEC[i]);
      chk_fields($sformatf("R2 R3 R4 R5 vector %0d", i));
    end
    chk_flags("R2 no error on clean words", 0, 0);

    // R6 reserved select
    send_bits({8'h0, 22'h3FFFFF, 2'b11}, 24);
    chk_fields("R6 reserved select");
    chk_flags("R6 no flag", 0, 0);

    // R7 short frame
    send_bits({8'h0, 22'h001234, 2'b10}, 23);
    chk_fields("R7 23-bit frame discarded");
    chk_flags("R7 frame flag short", 0, 1);
    send_bits({8'h0, 8'h00, 14'd77, 2'b00}, 24);
    model_word({8'h00, 14'd77, 2'b00});
    chk_flags("R7 frame flag sticky", 0, 1);

    // R10 reset clears
    do_reset();
    chk_flags("R10 reset clears flags", 0, 0);
    chk_fields("R10 reset values");

    // R7 long frame
    send_bits({7'h0, 25'h1_3FFFFE}, 25);
    chk_fields("R7 25-bit frame discarded");
    chk_flags("R7 frame flag long", 0, 1);

    // R3 zero divider
    do_reset();
    send_bits({8'h0, 8'hFF, 14'd0, 2'b00}, 24);
    chk_fields("R3 zero divider kept old value");
    chk_flags("R3 zero divider flag", 0, 1);

    // R8 one-cycle clock-high pulse
    do_reset();
    sdata = 1'b1; tick(3);
    sclk = 1'b1; tick(1);
    sclk = 1'b0; tick(6);
    chk_flags("R8 short clock high", 1, 0);
    sle = 1'b1; tick(3); sle = 1'b0; tick(6);   // discards the stray bit
    send_bits({8'h0, 22'h0ABCDE, 2'b10}, 24);
    model_word({22'h0ABCDE, 2'b10});
    chk_fields("R8 later good word still committed");
    chk_flags("R8 timing flag sticky", 1, 1);

    // R9 strobe coinciding with a clock edge
    do_reset();
    sdata = 1'b0; tick(3);
    sclk = 1'b1; sle = 1'b1; tick(3);
    sclk = 1'b0; sle = 1'b0; tick(6);
    chk_flags("R9 strobe too close to clock", 1, 1);

    do_reset();
    chk_flags("R10 reset clears timing flag", 0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog expired act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule